// File: doc/BRIEF.md
# CPU Presence Bitmap Port (Legacy Mode)

This block holds a map of which CPUs are present, one bit per CPU, where the bit index is the CPU's identifier. System software reads the map one byte at a time through a 32-byte I/O window. The map can only be read. The boot CPU's bit always reads as one. When a CPU is hot-added, its identifier arrives on a strobe. The matching bit is set, and a general-purpose event status level is raised towards the interrupt logic. That level stays high until firmware clears it with a clear strobe. CPUs are never removed, so no bit ever returns to zero.

The window has one exception to being read-only. Writing a zero byte into any of the first four bytes (the first 32-bit word) hands control to the modern hotplug register block. The `modern_mode` level goes high and stays high until reset. From then on, every read of this window returns zero. All other writes are dropped.

Accesses use a valid/ready request channel and a valid/ready read-response channel. The single response slot creates the back-pressure: `req_ready` is high only when the slot is empty or its data is being taken in the same cycle. A read is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its byte appears on `rsp_data` with `rsp_valid` after that same edge. The byte and `rsp_valid` stay unchanged until an edge where `rsp_ready` is high. Writes produce no response.

Top module: `cpu_present_port`

## Requirements
- R1: After reset, the map holds only bit 0, `gpe_sts` and `modern_mode` are low, and `rsp_valid` is low.
- R2: A read at window offset k (0 to 3) returns map bits 8k+7 down to 8k, with bit 8k in data bit 0. Offsets 4 to 31 read as 0x00.
- R3: Bit 0 of the map (the boot CPU) always reads as 1, including after a hot-add of identifier 0.
- R4: A hot-add strobe with an identifier below 32 sets that bit, and reads accepted from the next edge onwards see it. An identifier of 32 or above changes no bit and raises no event.
- R5: A valid hot-add sets `gpe_sts` one cycle later. `gpe_sts` stays high until a `gpe_clr` strobe. A hot-add in the same cycle as `gpe_clr` leaves it set.
- R6: A write of data 0x00 to offset 0, 1, 2 or 3 raises `modern_mode` after the accepting edge. It stays high until reset.
- R7: Writes with non-zero data, and writes to offsets 4 to 31, change neither the map nor `modern_mode`.
- R8: Once `modern_mode` is high, every read returns 0x00.
- R9: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. A held response keeps `rsp_data` stable. A write yields no response.
- R10: Map bits are never cleared except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset in the window |
| req_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data byte |
| hotadd_valid | input | 1 | Hot-add strobe |
| hotadd_id | input | 8 | Identifier of the added CPU |
| gpe_clr | input | 1 | Strobe that clears the event status |
| gpe_sts | output | 1 | Hot-add event status level |
| modern_mode | output | 1 | Legacy interface disabled, modern block active |

## Verification
- **Read response:** the byte is due one edge after the request is accepted. The scoreboard records the expected byte at the moment the bench sees `req_ready` high. The monitor compares it only in the cycle where `rsp_valid` and `rsp_ready` are both high.
- **Hot-add:** `gpe_sts` and the new map bit are due one edge after the strobe.
- **Mode switch:** `modern_mode` is due one edge after the write is accepted.
- **Sampling:** all inputs change on falling edges. Every sample is taken a quarter period later, so each check falls strictly between the edge that produces the result and the next rising edge.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  localparam int CPB_DATA_W = 8;

  typedef enum logic {
    CPB_LEGACY = 1'b0,
    CPB_MODERN = 1'b1
  } cpb_mode_e;
endpackage

// File: rtl/cpb_bitmap.sv
module cpb_bitmap #(
  parameter int NUM_CPUS = 32,
  parameter int ID_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                add_valid,
  input  logic [ID_W-1:0]     add_id,
  output logic                add_ok,
  output logic [NUM_CPUS-1:0] present
);
  localparam logic [ID_W:0] ID_LIMIT = (ID_W+1)'(NUM_CPUS);

  assign add_ok = add_valid && ({1'b0, add_id} < ID_LIMIT);

  generate
    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_bit
      if (i == 0) begin : g_boot
        assign present[i] = 1'b1;
      end else begin : g_hot
        logic q;
        always_ff @(posedge clk) begin
          if (!rst_n)                                 q <= 1'b0;
          else if (add_ok && add_id == ID_W'(i))      q <= 1'b1;
        end
        assign present[i] = q;
      end
    end
  endgenerate

  AST_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (present & $past(present)) == $past(present)); // R10
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (add_valid && !add_ok) |=> $stable(present)); // R4
endmodule

// File: rtl/cpb_gpe.sv
module cpb_gpe (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic sts
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sts <= 1'b0;
    else if (set) sts <= 1'b1;
    else if (clr) sts <= 1'b0;
  end

  AST_GPE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> sts); // R5
  AST_GPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr) |=> sts); // R5
endmodule

// File: rtl/cpb_mode.sv
module cpb_mode
  import cpb_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DWORD_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [CPB_DATA_W-1:0] wr_data,
  output logic                  modern
);
  cpb_mode_e mode_q;
  logic      trip;

  assign trip = wr_fire && (wr_addr < ADDR_W'(DWORD_BYTES)) && (wr_data == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    mode_q <= CPB_LEGACY;
    else if (trip) mode_q <= CPB_MODERN;
  end

  assign modern = (mode_q == CPB_MODERN);

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    modern |=> modern); // R6
  AST_MODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_data != '0 && !modern) |=> !modern); // R7
endmodule

// File: rtl/cpu_present_port.sv
module cpu_present_port
  import cpb_pkg::*;
#(
  parameter int NUM_CPUS  = 32,
  parameter int WIN_BYTES = 32,
  parameter int ID_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [$clog2(WIN_BYTES)-1:0]  req_addr,
  input  logic [CPB_DATA_W-1:0]         req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [CPB_DATA_W-1:0]         rsp_data,
  input  logic                          hotadd_valid,
  input  logic [ID_W-1:0]               hotadd_id,
  input  logic                          gpe_clr,
  output logic                          gpe_sts,
  output logic                          modern_mode
);
  localparam int ADDR_W   = $clog2(WIN_BYTES);
  localparam int WIN_BITS = WIN_BYTES * CPB_DATA_W;

  logic [NUM_CPUS-1:0]   present;
  logic                  add_ok;
  logic                  rd_fire;
  logic                  wr_fire;
  logic [WIN_BITS-1:0]   win_bits;
  logic [CPB_DATA_W-1:0] rd_byte;

  assign req_ready = !rsp_valid || rsp_ready;
  assign rd_fire   = req_valid && req_ready && !req_write;
  assign wr_fire   = req_valid && req_ready &&  req_write;

  cpb_bitmap #(.NUM_CPUS(NUM_CPUS), .ID_W(ID_W)) u_bitmap (
    .clk(clk), .rst_n(rst_n), .add_valid(hotadd_valid), .add_id(hotadd_id),
    .add_ok(add_ok), .present(present)
  );

  cpb_gpe u_gpe (
    .clk(clk), .rst_n(rst_n), .set(add_ok), .clr(gpe_clr), .sts(gpe_sts)
  );

  cpb_mode #(.ADDR_W(ADDR_W), .DWORD_BYTES(4)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(req_addr),
    .wr_data(req_wdata), .modern(modern_mode)
  );

  always_comb begin
    win_bits                 = '0;
    win_bits[NUM_CPUS-1:0]   = present;
  end

  assign rd_byte = win_bits[{req_addr, 3'b000} +: CPB_DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= modern_mode ? '0 : rd_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9
  AST_WR_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !rsp_valid); // R9
  AST_MODERN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && modern_mode) |=> (rsp_data == '0)); // R8
endmodule

// File: tb/cpu_present_port_bench.sv
module cpu_present_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_ready = 1'b1;
  logic       hotadd_valid = 1'b0;
  logic [7:0] hotadd_id = '0;
  logic       gpe_clr = 1'b0;
  logic       req_ready, rsp_valid, gpe_sts, modern_mode;
  logic [7:0] rsp_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_map = 32'h1;
  logic        m_modern = 1'b0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  cpu_present_port u_cpu_present_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .hotadd_valid(hotadd_valid), .hotadd_id(hotadd_id), .gpe_clr(gpe_clr),
    .gpe_sts(gpe_sts), .modern_mode(modern_mode)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte(input logic [4:0] a);
    if (m_modern || a > 5'd3) return 8'h00;
    return m_map[{a[1:0], 3'b000} +: 8];
  endfunction

  task automatic do_read(input logic [4:0] a, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #5;
    while (!req_ready) begin @(negedge clk); #5; end
    exp_q.push_back(model_byte(a));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #5;
    while (!req_ready) begin @(negedge clk); #5; end
    if (a < 5'd4 && d == 8'h00) m_modern = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic hot_add(input logic [7:0] id, input logic clr);
    hotadd_valid = 1'b1; hotadd_id = id; gpe_clr = clr;
    @(negedge clk);
    hotadd_valid = 1'b0; gpe_clr = 1'b0;
    if (id < 8'd32) m_map[id[4:0]] = 1'b1;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops and compares on each response handshake
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk("R9 unexpected response", rsp_data, 8'hxx);
        else chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 rsp_valid", {7'b0, rsp_valid}, 8'h00);
    chk("R1 gpe_sts", {7'b0, gpe_sts}, 8'h00);
    chk("R1 modern_mode", {7'b0, modern_mode}, 8'h00);
    @(negedge clk);
    do_read(5'd0, "R1 R3 byte0 after reset");
    for (int k = 1; k < 4; k++) do_read(5'(k), "R1 R2 map byte after reset");
    do_read(5'd4, "R2 offset 4 zero");
    do_read(5'd31, "R2 offset 31 zero");
    drain();

    hot_add(8'd5, 1'b0);
    chk("R5 gpe_sts after hot-add", {7'b0, gpe_sts}, 8'h01);
    do_read(5'd0, "R4 bit5 visible");
    hot_add(8'd17, 1'b0);
    do_read(5'd2, "R4 bit17 visible");
    hot_add(8'd31, 1'b0);
    do_read(5'd3, "R4 bit31 visible");
    hot_add(8'd0, 1'b0);
    do_read(5'd0, "R3 boot bit stays set");
    drain();

    gpe_clr = 1'b1; @(negedge clk); gpe_clr = 1'b0;
    chk("R5 gpe cleared", {7'b0, gpe_sts}, 8'h00);
    hot_add(8'd32, 1'b0);
    chk("R4 out-of-range no event", {7'b0, gpe_sts}, 8'h00);
    hot_add(8'd200, 1'b0);
    chk("R4 out-of-range no event", {7'b0, gpe_sts}, 8'h00);
    do_read(5'd4, "R4 no bit 32");
    do_read(5'd0, "R4 map unchanged");
    hot_add(8'd9, 1'b1);
    chk("R5 set wins over clear", {7'b0, gpe_sts}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R5 gpe holds", {7'b0, gpe_sts}, 8'h01);
    do_read(5'd1, "R4 bit9 visible");
    drain();

    do_write(5'd0, 8'hFF);
    do_write(5'd1, 8'h00 + 8'h5A);
    do_write(5'd4, 8'h00);
    do_write(5'd31, 8'h00);
    chk("R7 mode unchanged", {7'b0, modern_mode}, 8'h00);
    do_read(5'd0, "R7 map unchanged byte0");
    do_read(5'd1, "R7 map unchanged byte1");
    do_read(5'd4, "R7 offset 4 still zero");
    drain();

    // back-pressure
    rsp_ready = 1'b0;
    do_read(5'd2, "R9 held response");
    repeat (3) @(negedge clk);
    #5;
    chk("R9 req_ready low while held", {7'b0, req_ready}, 8'h00);
    chk("R9 rsp_valid held", {7'b0, rsp_valid}, 8'h01);
    chk("R9 rsp_data stable", rsp_data, model_byte(5'd2));
    @(negedge clk);
    rsp_ready = 1'b1;
    drain();

    do_write(5'd2, 8'h00);
    chk("R6 modern_mode raised", {7'b0, modern_mode}, 8'h01);
    do_read(5'd0, "R8 read zero in modern");
    do_read(5'd3, "R8 read zero in modern");
    do_write(5'd0, 8'hFF);
    repeat (2) @(negedge clk);
    chk("R6 modern_mode sticky", {7'b0, modern_mode}, 8'h01);
    drain();

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_map = 32'h1; m_modern = 1'b0;
    #5;
    chk("R1 R6 mode cleared by reset", {7'b0, modern_mode}, 8'h00);
    chk("R1 gpe cleared by reset", {7'b0, gpe_sts}, 8'h00);
    @(negedge clk);
    do_read(5'd0, "R1 map after reset");
    do_read(5'd2, "R1 R10 map after reset");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule